// File: doc/BRIEF.md
# TDM Slot Receiver with Idle-Word Filter

This block receives serial words from a time-division-multiplexed data line shared by several nodes. The line carries a fixed number of time slots per frame, each holding a fixed-width word sent most significant bit first. The block works from a one-cycle bit strobe and a frame-sync input, both synchronous to the system clock. From these it keeps track of the current slot and the bit position within it. A per-slot enable mask decides which slots this node listens to. Bits in all other slots are shifted in and then dropped.

When an enabled slot finishes, the assembled word is compared against a programmable idle keyword. A match is discarded silently, so an idle line never wakes the host. Any other word is latched into a single holding register, along with the number of the slot it came from, and the receive interrupt is raised. The host reads the word by pulsing a read strobe, which clears both the valid flag and the interrupt. A word that arrives while the previous one is still unread replaces it and sets an overflow flag.

Top module: `tdm_kw_rx`

## Requirements
- R1: After a synchronous reset, `rx_valid`, `rx_irq` and `rx_ovf` are 0, and `rx_word` and `rx_slot` are 0.
- R2: A bit strobe with `fsync` high carries the MSB of slot 0. The slot and bit counters restart there even in the middle of a slot, and the partly received word is abandoned.
- R3: Each slot carries WORD_W bits. The first bit received becomes bit WORD_W-1 of the word and the last becomes bit 0.
- R4: Mask bit n enables slot n, so value 0x01 selects the first slot, 0x02 the second and 0x40 the seventh. Words from disabled slots leave `rx_word`, `rx_slot`, `rx_valid` and `rx_ovf` unchanged.
- R5: A word equal to `keyword` in an enabled slot is dropped. It does not raise `rx_irq`, and it leaves the holding register unchanged.
- R6: Any other word in an enabled slot appears on `rx_word`, with its slot number on `rx_slot`, in the clock cycle after the strobe that carried its last bit. In that same cycle `rx_valid` and `rx_irq` go to 1.
- R7: If a word is accepted while `rx_valid` is 1 and no read occurs in that cycle, `rx_ovf` goes to 1 and `rx_word` holds the newer word.
- R8: A cycle with `rd_en` high clears `rx_valid`, `rx_irq` and `rx_ovf`. If a word is accepted in the same cycle, `rx_valid` stays 1 with the new word and `rx_ovf` is 0.
- R9: Bits that arrive before the first frame sync, or after the last slot of a frame and before the next frame sync, are never accepted.
- R10: Cycles with `bit_en` low do not change the slot position, the bit position or the word being assembled, whatever `fsync` and `rx_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking a valid bit on `rx_data` |
| fsync | input | 1 | Frame sync, sampled with `bit_en`; marks the first bit of slot 0 |
| rx_data | input | 1 | Serial TDM data |
| slot_mask | input | NSLOTS | Per-slot receive enable, bit n for slot n |
| keyword | input | WORD_W | Idle word that is dropped without an interrupt |
| rd_en | input | 1 | Host read strobe; clears valid, interrupt and overflow |
| rx_word | output | WORD_W | Last accepted word |
| rx_slot | output | SLOT_W | Slot number of `rx_word` |
| rx_valid | output | 1 | Holding register contains an unread word |
| rx_ovf | output | 1 | An unread word was overwritten |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its defaults of seven slots of fourteen bits, with the all-ones word as the idle keyword. These sizes make the first and last slots reachable, including the moment a frame runs out after the seventh slot. They also make it possible to compare the mask values 0x02, 0x40 and 0x7F against a reference model on every cycle. With a full frame lasting about two hundred clocks, the bench can also cover an abandoned partial slot, an overflow across two frames, and a read that coincides with the last bit of a new word.

// File: rtl/tdmrx_pkg.sv
`timescale 1ns/1ps
package tdmrx_pkg;

    // Whether the receiver is inside a frame or waiting for the next sync.
    typedef enum logic {
        FR_OUT = 1'b0,
        FR_IN  = 1'b1
    } frame_state_e;

    // Counter width able to index n positions (at least one bit).
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdmrx_framer.sv
`timescale 1ns/1ps
module tdmrx_framer
    import tdmrx_pkg::*;
#(
    parameter int NSLOTS = 7,
    parameter int WORD_W = 14,
    localparam int SLOT_W = cnt_w(NSLOTS),
    localparam int BIT_W  = cnt_w(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              fsync,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              word_done
);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOTS - 1);

    frame_state_e      state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BIT_W-1:0]  cur_bit;
    logic              in_frame;
    logic              last_bit;

    // Frame sync overrides the running position: this strobe is slot 0, bit 0.
    always_comb begin
        in_frame  = fsync || (state_q == FR_IN);
        cur_slot  = fsync ? '0 : slot_q;
        cur_bit   = fsync ? '0 : bit_q;
        last_bit  = (cur_bit == LAST_BIT);
        word_done = bit_en && in_frame && last_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_OUT;
            slot_q  <= '0;
            bit_q   <= '0;
        end else if (bit_en && in_frame) begin
            if (last_bit) begin
                bit_q <= '0;
                if (cur_slot == LAST_SLOT) begin
                    state_q <= FR_OUT;
                    slot_q  <= '0;
                end else begin
                    state_q <= FR_IN;
                    slot_q  <= cur_slot + 1'b1;
                end
            end else begin
                state_q <= FR_IN;
                slot_q  <= cur_slot;
                bit_q   <= cur_bit + 1'b1;
            end
        end
    end

    // R2: a sync strobe places the receiver at slot 0, second bit.
    if (WORD_W > 1) begin : g_sync_chk
        a_r2_fsync_restart: assert property (@(posedge clk) disable iff (rst)
            (bit_en && fsync) |=> (state_q == FR_IN && slot_q == '0 && bit_q == BIT_W'(1)))
            else $error("R2: frame sync did not restart position");
    end

    // R9: the last bit of the last slot leaves the frame.
    a_r9_frame_end: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !fsync && state_q == FR_IN && slot_q == LAST_SLOT && bit_q == LAST_BIT)
        |=> (state_q == FR_OUT))
        else $error("R9: frame did not end after last slot");

    // R3: bit position never reaches the word width.
    a_r3_bit_range: assert property (@(posedge clk) disable iff (rst)
        bit_q <= LAST_BIT)
        else $error("R3: bit position out of range");

    // R10: idle cycles leave the position alone.
    a_r10_pos_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(bit_q) && $stable(slot_q) && $stable(state_q)))
        else $error("R10: position moved without a bit strobe");

endmodule

// File: rtl/tdmrx_shifter.sv
`timescale 1ns/1ps
module tdmrx_shifter #(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              din,
    output logic [WORD_W-1:0] word_next
);
    // Only WORD_W-1 earlier bits are kept; the current bit completes the word.
    logic [WORD_W-2:0] sh_q;

    assign word_next = {sh_q, din};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (bit_en) begin
            sh_q <= word_next[WORD_W-2:0];
        end
    end

    // R10: no strobe, no shift.
    a_r10_shift_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(sh_q))
        else $error("R10: shift register moved without a bit strobe");

endmodule

// File: rtl/tdmrx_hold.sv
`timescale 1ns/1ps
module tdmrx_hold
    import tdmrx_pkg::*;
#(
    parameter int NSLOTS = 7,
    parameter int WORD_W = 14,
    localparam int SLOT_W = cnt_w(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_done,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [WORD_W-1:0] word_next,
    input  logic [NSLOTS-1:0] slot_mask,
    input  logic [WORD_W-1:0] keyword,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rx_word,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              rx_valid,
    output logic              rx_ovf
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [SLOT_W-1:0] slot;
        logic              valid;
        logic              ovf;
    } hold_t;

    hold_t h_q;
    logic  slot_on;
    logic  is_idle;
    logic  accept;

    always_comb begin
        slot_on = slot_mask[cur_slot];
        is_idle = (word_next == keyword);
        accept  = word_done && slot_on && !is_idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else if (accept) begin
            h_q.word  <= word_next;
            h_q.slot  <= cur_slot;
            h_q.valid <= 1'b1;
            h_q.ovf   <= h_q.valid && !rd_en;
        end else if (rd_en) begin
            h_q.valid <= 1'b0;
            h_q.ovf   <= 1'b0;
        end
    end

    assign rx_word  = h_q.word;
    assign rx_slot  = h_q.slot;
    assign rx_valid = h_q.valid;
    assign rx_ovf   = h_q.ovf;

    // R5: an idle word touches neither data nor flags.
    a_r5_keyword_drop: assert property (@(posedge clk) disable iff (rst)
        (word_done && (word_next == keyword) && !rd_en)
        |=> ($stable(h_q.word) && $stable(h_q.valid) && $stable(h_q.ovf)))
        else $error("R5: keyword word changed the holding register");

    // R4: a word ending in a disabled slot is discarded.
    a_r4_masked_slot: assert property (@(posedge clk) disable iff (rst)
        (word_done && !slot_mask[cur_slot] && !rd_en)
        |=> ($stable(h_q.word) && $stable(h_q.slot) && $stable(h_q.valid)))
        else $error("R4: disabled slot reached the holding register");

    // R8: a read with nothing arriving empties the register.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !word_done) |=> (!h_q.valid && !h_q.ovf))
        else $error("R8: read did not clear valid and overflow");

    // R7: overflow can only rise while an unread word is held.
    a_r7_ovf_source: assert property (@(posedge clk) disable iff (rst)
        $rose(h_q.ovf) |-> $past(h_q.valid))
        else $error("R7: overflow without an unread word");

endmodule

// File: rtl/tdm_kw_rx.sv
`timescale 1ns/1ps
module tdm_kw_rx
    import tdmrx_pkg::*;
#(
    parameter int NSLOTS = 7,
    parameter int WORD_W = 14,
    localparam int SLOT_W = cnt_w(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic              rx_data,
    input  logic [NSLOTS-1:0] slot_mask,
    input  logic [WORD_W-1:0] keyword,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rx_word,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              rx_valid,
    output logic              rx_ovf,
    output logic              rx_irq
);
    logic [SLOT_W-1:0] cur_slot;
    logic              word_done;
    logic [WORD_W-1:0] word_next;

    tdmrx_framer #(.NSLOTS(NSLOTS), .WORD_W(WORD_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .fsync     (fsync),
        .cur_slot  (cur_slot),
        .word_done (word_done)
    );

    tdmrx_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .din       (rx_data),
        .word_next (word_next)
    );

    tdmrx_hold #(.NSLOTS(NSLOTS), .WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .word_done (word_done),
        .cur_slot  (cur_slot),
        .word_next (word_next),
        .slot_mask (slot_mask),
        .keyword   (keyword),
        .rd_en     (rd_en),
        .rx_word   (rx_word),
        .rx_slot   (rx_slot),
        .rx_valid  (rx_valid),
        .rx_ovf    (rx_ovf)
    );

    // The interrupt is a level that follows an unread word.
    assign rx_irq = rx_valid;

    // R6: an accepted word shows up with its interrupt in the next cycle.
    a_r6_irq_follows: assert property (@(posedge clk) disable iff (rst)
        (word_done && slot_mask[cur_slot] && (word_next != keyword))
        |=> (rx_irq && rx_word == $past(word_next) && rx_slot == $past(cur_slot)))
        else $error("R6: accepted word not presented with interrupt");

endmodule

// File: tb/tb_tdm_kw_rx.sv
`timescale 1ns/1ps
module tb_tdm_kw_rx;
    localparam int NS = 7;
    localparam int W  = 14;
    localparam int SW = 3;
    localparam int WMASK = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_en = 1'b0;
    logic          fsync = 1'b0;
    logic          rx_data = 1'b0;
    logic          rd_en = 1'b0;
    logic [NS-1:0] slot_mask = 7'h02;
    logic [W-1:0]  keyword = 14'h3FFF;
    logic [W-1:0]  rx_word;
    logic [SW-1:0] rx_slot;
    logic          rx_valid, rx_ovf, rx_irq;

    tdm_kw_rx dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .fsync(fsync), .rx_data(rx_data),
        .slot_mask(slot_mask), .keyword(keyword), .rd_en(rd_en),
        .rx_word(rx_word), .rx_slot(rx_slot), .rx_valid(rx_valid),
        .rx_ovf(rx_ovf), .rx_irq(rx_irq)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int gap    = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // Behavioural reference: position as integers, slot NS means outside a frame.
    int m_slot = NS, m_bit = 0, m_sh = 0, m_word = 0, m_sl = 0;
    bit m_valid = 0, m_ovf = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_slot = NS; m_bit = 0; m_sh = 0; m_word = 0; m_sl = 0;
            m_valid = 0; m_ovf = 0;
        end else begin
            int  cs, cb;
            bit  take;
            take = 0;
            if (bit_en) begin
                cs = fsync ? 0 : m_slot;
                cb = fsync ? 0 : m_bit;
                m_sh = ((m_sh << 1) | int'(rx_data)) & WMASK;
                if (cs < NS) begin
                    if (cb == W - 1) begin
                        if (slot_mask[cs] && m_sh != int'(keyword)) take = 1;
                        m_bit = 0;
                        m_slot = cs + 1;
                    end else begin
                        m_bit = cb + 1;
                        m_slot = cs;
                    end
                end
            end
            if (take) begin
                m_ovf   = m_valid && !rd_en;
                m_valid = 1;
                m_word  = m_sh;
                m_sl    = cs;
            end else if (rd_en) begin
                m_valid = 0;
                m_ovf   = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 model valid", rx_valid, m_valid);
            chk("R6 model irq", rx_irq, m_valid);
            chk("R7 model ovf", rx_ovf, m_ovf);
            chk("R3 model word", rx_word, m_word);
            chk("R4 model slot", rx_slot, m_sl);
        end
    end

    task automatic do_bit(input bit fs, input bit d, input bit rd);
        @(negedge clk);
        bit_en = 1'b1; fsync = fs; rx_data = d; rd_en = rd;
        @(negedge clk);
        bit_en = 1'b0; rd_en = 1'b0;
        fsync = 1'($urandom); rx_data = 1'($urandom);
        repeat (gap) begin
            @(negedge clk);
            fsync = 1'($urandom); rx_data = 1'($urandom);
        end
    endtask

    task automatic send_word(input logic [W-1:0] w, input bit fs, input bit rd_last);
        for (int i = W - 1; i >= 0; i--)
            do_bit(fs && (i == W - 1), w[i], rd_last && (i == 0));
    endtask

    task automatic send_frame(input int tgt, input logic [W-1:0] w, input bit rd_last);
        for (int s = 0; s < NS; s++)
            send_word((s == tgt) ? w : 14'h0F0F, s == 0, rd_last && (s == tgt));
    endtask

    task automatic host_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset valid", rx_valid, 0);
        chk("R1 reset irq", rx_irq, 0);
        chk("R1 reset ovf", rx_ovf, 0);
        chk("R1 reset word", rx_word, 0);
        chk("R1 reset slot", rx_slot, 0);

        // Traffic before any frame sync
        send_word(14'h0123, 0, 0);
        chk("R9 no capture before first sync", rx_valid, 0);

        // Frame A: only slot 1 enabled
        send_word(14'h1234, 1, 0);
        chk("R4 slot 0 disabled", rx_valid, 0);
        send_word(14'h0ABC, 0, 0);
        chk("R3 MSB-first word", rx_word, 14'h0ABC);
        chk("R6 valid after last bit", rx_valid, 1);
        chk("R6 irq after last bit", rx_irq, 1);
        chk("R6 slot number", rx_slot, 1);
        for (int s = 2; s < NS; s++) send_word(14'h0F0F, 0, 0);
        chk("R4 disabled slots keep word", rx_word, 14'h0ABC);
        chk("R4 disabled slots no overflow", rx_ovf, 0);

        // Past the end of the frame, with every slot enabled
        slot_mask = 7'h7F;
        send_word(14'h0777, 0, 0);
        send_word(14'h0555, 0, 0);
        chk("R9 bits after frame ignored", rx_word, 14'h0ABC);
        chk("R9 no overflow after frame", rx_ovf, 0);
        slot_mask = 7'h02;

        host_read();
        chk("R8 read clears valid", rx_valid, 0);
        chk("R8 read clears irq", rx_irq, 0);

        // Frame B: idle keyword in the enabled slot
        send_frame(1, 14'h3FFF, 0);
        chk("R5 keyword no irq", rx_irq, 0);
        chk("R5 keyword no valid", rx_valid, 0);
        chk("R5 keyword leaves word", rx_word, 14'h0ABC);

        // Frames C and D: overflow
        send_frame(1, 14'h2001, 0);
        chk("R6 word C valid", rx_valid, 1);
        chk("R7 no overflow yet", rx_ovf, 0);
        send_frame(1, 14'h1555, 0);
        chk("R7 overflow set", rx_ovf, 1);
        chk("R7 newer word kept", rx_word, 14'h1555);
        host_read();
        chk("R8 read clears overflow", rx_ovf, 0);
        chk("R8 read clears valid after overflow", rx_valid, 0);

        // Read coinciding with a new word
        send_frame(1, 14'h0100, 0);
        send_frame(1, 14'h0200, 1);
        chk("R8 coincident read keeps valid", rx_valid, 1);
        chk("R8 coincident read no overflow", rx_ovf, 0);
        chk("R8 coincident read new word", rx_word, 14'h0200);
        host_read();

        // Frame sync in the middle of a slot
        send_word(14'h0F0F, 1, 0);
        for (int i = 0; i < 5; i++) do_bit(0, 1'b1, 0);
        send_word(14'h1111, 1, 0);
        send_word(14'h0333, 0, 0);
        chk("R2 restart word", rx_word, 14'h0333);
        chk("R2 restart slot", rx_slot, 1);
        chk("R2 restart no overflow", rx_ovf, 0);
        for (int s = 2; s < NS; s++) send_word(14'h0F0F, 0, 0);
        host_read();

        // Last slot only, with long gaps between strobes
        slot_mask = 7'h40;
        gap = 5;
        for (int s = 0; s < NS - 1; s++) send_word(14'h2468, s == 0, 0);
        chk("R4 slots 0-5 disabled by 0x40", rx_valid, 0);
        send_word(14'h0C0D, 0, 0);
        chk("R10 word across gaps", rx_word, 14'h0C0D);
        chk("R4 slot 6 number", rx_slot, 6);
        gap = 0;

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule